// File: doc/BRIEF.md
# Status-Tagged ADC Channel Demultiplexer

This block sits behind a serial ADC read-out engine. It takes 24-bit sample words over a valid/ready handshake and routes each one to a per-channel register, using a channel number carried inside the word. All channel registers are presented together as one wide word, 16 lanes of 32 bits each, with a one-cycle valid strobe. A downstream channel packer consumes this word.

Each sample has 16 bits of two's-complement conversion data in its upper part and an 8-bit status byte in its lower part. The top nibble of the status byte names the destination channel. The data is sign-extended to fill its lane. A capture-mode input picks one of two behaviours. In mode 0 the block emits a word for every sample, and the other channels keep their last values. In mode 1 the block collects one sample from each channel set in a sequence mask, then emits a single word. In that word the unmasked lanes are zero. The block then clears its stored state and starts a new sequence.

Top module: `adc_tag_demux`

## Requirements
- R1: `in_ready_o` is 1 in every cycle, including during reset.
- R2: For an input word `w`, the destination channel is `w[7:4]` (0 to 15) and the conversion data is `w[23:8]`. Bits `w[3:0]` have no effect on any output. Channel `c` occupies `out_data_o[32*c+31 : 32*c]`.
- R3: The lane value is the 16-bit data sign-extended to 32 bits. Bit 15 of the data is copied into bits 31:16 of the lane.
- R4: In mode 0 (`mode_i`=0), every accepted sample produces `out_valid_o`=1 on the clock edge after the sample edge. `out_valid_o` is never 1 unless a sample was accepted on the previous edge.
- R5: In mode 0, a sample writes only its own lane. Every other lane in the emitted word keeps its previous value.
- R6: In mode 1, no word is emitted until every channel set in `seq_mask_i` has arrived. The sample that completes the set produces one `out_valid_o` pulse one edge later. In that word, lanes whose mask bit is 0 are zero. A zero mask never completes.
- R7: In mode 1, a sample whose channel is not in `seq_mask_i` is discarded. It neither counts toward completion nor appears in any later word.
- R8: After a mode-1 word is emitted, the arrival tracking and all stored lane values are cleared. Lanes not written afterwards read as zero.
- R9: Any change of `mode_i` clears the arrival tracking, so channels received before the change do not count toward a mode-1 sequence.
- R10: Synchronous active-high reset sets `out_valid_o` to 0, `out_data_o` to 0 and all stored lanes to 0.
- R11: In mode 1, a repeated sample for an already-received channel replaces the stored value. The emitted word carries the latest one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Capture mode: 0 emit per sample, 1 emit per completed sequence |
| seq_mask_i | input | 16 | Channels that make up a mode-1 sequence |
| in_valid_i | input | 1 | Sample word valid |
| in_word_i | input | 24 | Sample word: data [23:8], status [7:0] |
| in_ready_o | output | 1 | Always-asserted ready |
| out_valid_o | output | 1 | One-cycle strobe for a new channel word |
| out_data_o | output | 512 | 16 sign-extended 32-bit channel lanes |

## Verification
A wrong lane register shows at the ports on the next emitted word. In mode 0 that is one edge after the next sample on any channel. A corrupted arrival-tracking mask shows up as a missing or extra `out_valid_o` pulse. That pulse appears on the edge after the sample that should, or should not, complete a mode-1 sequence. Clearing that fails after an emitted sequence, or after a mode change, stays hidden until the next word. It then shows as nonzero stale lanes or as a sequence that completes early. The bench therefore switches modes and emits words right after each emitted sequence, so that these states are exposed.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

    localparam int NUM_CH  = 16;
    localparam int SMP_W   = 16;
    localparam int STAT_W  = 8;
    localparam int ID_W    = $clog2(NUM_CH);
    localparam int LANE_W  = 32;
    localparam int WORD_W  = SMP_W + STAT_W;
    localparam int OUT_W   = NUM_CH * LANE_W;

    typedef struct packed {
        logic [SMP_W-1:0]  data;
        logic [STAT_W-1:0] status;
    } sample_t;

    typedef enum logic {
        CAP_EACH = 1'b0,
        CAP_SEQ  = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic [ID_W-1:0]   ch;
        logic [LANE_W-1:0] value;
    } route_t;

    function automatic logic [LANE_W-1:0] widen(input logic [SMP_W-1:0] d);
        return {{(LANE_W-SMP_W){d[SMP_W-1]}}, d};
    endfunction

    function automatic logic [ID_W-1:0] tag_of(input logic [STAT_W-1:0] s);
        return s[STAT_W-1 -: ID_W];
    endfunction

endpackage

// File: rtl/tag_decoder.sv
module tag_decoder
    import adc_demux_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          valid_i,
    input  sample_t       word_i,
    output route_t        route_o,
    output logic [CH-1:0] hit_o
);

    always_comb begin
        route_o.ch    = tag_of(word_i.status);
        route_o.value = widen(word_i.data);
    end

    for (genvar i = 0; i < CH; i++) begin : g_hit
        assign hit_o[i] = valid_i && (route_o.ch == ID_W'(i));
    end

endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
    import adc_demux_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  cap_mode_e     mode_i,
    input  logic          mode_chg_i,
    input  logic [CH-1:0] hit_i,
    input  logic [CH-1:0] mask_i,
    output logic [CH-1:0] wr_o,
    output logic          emit_o,
    output logic          done_o
);

    logic [CH-1:0] seen_q;
    logic [CH-1:0] take;
    logic [CH-1:0] base;
    logic [CH-1:0] seen_nx;

    always_comb begin
        take    = (mode_i == CAP_SEQ) ? (hit_i & mask_i) : '0;
        base    = mode_chg_i ? '0 : seen_q;
        seen_nx = base | take;
        done_o  = (mode_i == CAP_SEQ) && (|mask_i) && (|take)
                  && ((seen_nx & mask_i) == mask_i);
        wr_o    = (mode_i == CAP_SEQ) ? take : hit_i;
        emit_o  = (mode_i == CAP_SEQ) ? done_o : (|hit_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (mode_i != CAP_SEQ || done_o) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_nx;
        end
    end

    AST_TRACK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (seen_q == '0)); // R8

    AST_MODECHG_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode_chg_i && mode_i == CAP_SEQ) |=> ((seen_q & ~$past(take)) == '0)); // R9

    AST_UNMASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CAP_SEQ && (hit_i & ~mask_i) != '0) |-> ((wr_o & ~mask_i) == '0)); // R7

endmodule

// File: rtl/lane_bank.sv
module lane_bank
    import adc_demux_pkg::*;
#(
    parameter int CH = NUM_CH,
    parameter int LW = LANE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CH-1:0]  wr_i,
    input  logic [LW-1:0]  value_i,
    input  logic           clr_i,
    input  logic [CH-1:0]  keep_i,
    output logic [CH*LW-1:0] view_o
);

    logic [LW-1:0] lane_q [CH];

    for (genvar i = 0; i < CH; i++) begin : g_lane
        logic [LW-1:0] merged;

        always_comb begin
            merged = wr_i[i] ? value_i : lane_q[i];
            view_o[i*LW +: LW] = keep_i[i] ? merged : '0;
        end

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                lane_q[i] <= '0;
            end else if (wr_i[i]) begin
                lane_q[i] <= value_i;
            end
        end

        AST_LANE_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!wr_i[i] && !clr_i) |=> $stable(lane_q[i])); // R5
    end

endmodule

// File: rtl/adc_tag_demux.sv
module adc_tag_demux
    import adc_demux_pkg::*;
#(
    parameter int CH = NUM_CH,
    parameter int LW = LANE_W,
    parameter int WW = WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_i,
    input  logic [CH-1:0]   seq_mask_i,
    input  logic            in_valid_i,
    input  logic [WW-1:0]   in_word_i,
    output logic            in_ready_o,
    output logic            out_valid_o,
    output logic [CH*LW-1:0] out_data_o
);

    cap_mode_e      mode;
    cap_mode_e      mode_q;
    logic           mode_chg;
    route_t         route;
    logic [CH-1:0]  hit;
    logic [CH-1:0]  wr;
    logic           emit;
    logic           done;
    logic [CH-1:0]  keep;
    logic [CH*LW-1:0] view;

    assign mode       = cap_mode_e'(mode_i);
    assign mode_chg   = (mode != mode_q);
    assign in_ready_o = 1'b1;
    assign keep       = (mode == CAP_SEQ) ? seq_mask_i : '1;

    tag_decoder #(.CH(CH)) u_dec (
        .valid_i (in_valid_i),
        .word_i  (sample_t'(in_word_i)),
        .route_o (route),
        .hit_o   (hit)
    );

    seq_tracker #(.CH(CH)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .mode_chg_i (mode_chg),
        .hit_i      (hit),
        .mask_i     (seq_mask_i),
        .wr_o       (wr),
        .emit_o     (emit),
        .done_o     (done)
    );

    lane_bank #(.CH(CH), .LW(LW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .value_i (route.value),
        .clr_i   (done),
        .keep_i  (keep),
        .view_o  (view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= CAP_EACH;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            mode_q      <= mode;
            out_valid_o <= emit;
            if (emit) begin
                out_data_o <= view;
            end
        end
    end

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> $past(in_valid_i)); // R4

    AST_EACH_EMITS: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode == CAP_EACH) |=> out_valid_o); // R4

    for (genvar i = 0; i < CH; i++) begin : g_chk
        AST_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
            (out_valid_o && $past(mode_i) && !$past(seq_mask_i[i]))
            |-> (out_data_o[i*LW +: LW] == '0)); // R6
    end

endmodule

// File: tb/adc_tag_demux_tb.sv
module adc_tag_demux_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_i = 1'b0;
    logic [15:0]  seq_mask_i = '0;
    logic         in_valid_i = 1'b0;
    logic [23:0]  in_word_i = '0;
    logic         in_ready_o;
    logic         out_valid_o;
    logic [511:0] out_data_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [16];

    always #2.5 clk = ~clk;

    adc_tag_demux u_dut (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .seq_mask_i  (seq_mask_i),
        .in_valid_i  (in_valid_i),
        .in_word_i   (in_word_i),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o)
    );

    // {sample word, expected lane value}
    localparam logic [55:0] VEC [8] = '{
        {24'h12343A, 32'h0000_1234},
        {24'h8001F0, 32'hFFFF_8001},
        {24'h7FFF05, 32'h0000_7FFF},
        {24'hFFFF7F, 32'hFFFF_FFFF},
        {24'h004230, 32'h0000_0042},
        {24'hA5A59C, 32'hFFFF_A5A5},
        {24'h0001F1, 32'h0000_0001},
        {24'hC000C0, 32'hFFFF_C000}
    };

    function automatic logic [31:0] lane(input int c);
        return out_data_o[c*32 +: 32];
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_word_i  = w;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 16; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        // R10, R1: reset state
        chk({31'd0, out_valid_o}, 32'd0, "R10 valid in reset");
        chk({31'd0, in_ready_o}, 32'd1, "R1 ready in reset");
        rst = 1'b0;
        @(negedge clk);
        chk({31'd0, out_valid_o}, 32'd0, "R10 valid after reset");
        chk({31'd0, |out_data_o}, 32'd0, "R10 data after reset");

        // mode 0 vector walk: R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            send(VEC[v][55:32]);
            model[VEC[v][39:36]] = VEC[v][31:0];
            chk({31'd0, out_valid_o}, 32'd1, "R4 valid per sample");
            chk(lane(int'(VEC[v][39:36])), VEC[v][31:0], "R2 R3 lane value");
            for (int c = 0; c < 16; c++) chk(lane(c), model[c], "R5 other lanes hold");
            chk({31'd0, in_ready_o}, 32'd1, "R1 ready");
        end
        @(negedge clk);
        chk({31'd0, out_valid_o}, 32'd0, "R4 single pulse");

        // mode 1, mask = channels 0 and 2
        mode_i = 1'b1;
        seq_mask_i = 16'h0005;
        @(negedge clk);
        send(24'h111100);
        chk({31'd0, out_valid_o}, 32'd0, "R6 no emit partial");
        send(24'h555550);
        chk({31'd0, out_valid_o}, 32'd0, "R7 unmasked no emit");
        send(24'h82220A);
        chk({31'd0, out_valid_o}, 32'd0, "R11 repeat no emit");
        send(24'h333327);
        chk({31'd0, out_valid_o}, 32'd1, "R6 emit on completion");
        chk(lane(0), 32'hFFFF_8222, "R11 latest value");
        chk(lane(2), 32'h0000_3333, "R6 lane 2");
        chk(lane(5), 32'd0, "R7 discarded lane 5");
        chk(lane(15), 32'd0, "R6 unmasked zero");
        @(negedge clk);
        chk({31'd0, out_valid_o}, 32'd0, "R6 single pulse");

        // R8: tracking restarted after emission
        send(24'h444420);
        chk({31'd0, out_valid_o}, 32'd0, "R8 tracking cleared");
        send(24'h666600);
        chk({31'd0, out_valid_o}, 32'd1, "R8 second sequence");
        chk(lane(0), 32'h0000_6666, "R8 lane 0");
        chk(lane(2), 32'h0000_4444, "R8 lane 2");

        // R9: mode change drops partial sequence
        seq_mask_i = 16'h0003;
        send(24'h0A0A00);
        chk({31'd0, out_valid_o}, 32'd0, "R9 partial");
        mode_i = 1'b0;
        send(24'h0B0B10);
        chk({31'd0, out_valid_o}, 32'd1, "R9 mode0 emits");
        mode_i = 1'b1;
        send(24'h0C0C10);
        chk({31'd0, out_valid_o}, 32'd0, "R9 partial forgotten");
        send(24'h0D0D00);
        chk({31'd0, out_valid_o}, 32'd1, "R9 completes after restart");
        chk(lane(1), 32'h0000_0C0C, "R9 lane 1");
        chk(lane(0), 32'h0000_0D0D, "R9 lane 0");

        // R8: stored values cleared after emission
        mode_i = 1'b0;
        send(24'h7777 << 8 | 24'h003F);
        chk({31'd0, out_valid_o}, 32'd1, "R8 mode0 emit");
        chk(lane(3), 32'h0000_7777, "R8 lane 3 written");
        chk(lane(0), 32'd0, "R8 lane 0 cleared");
        chk(lane(1), 32'd0, "R8 lane 1 cleared");
        chk(lane(15), 32'd0, "R8 lane 15 cleared");

        // R10: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({31'd0, out_valid_o}, 32'd0, "R10 valid cleared");
        chk({31'd0, |out_data_o}, 32'd0, "R10 data cleared");
        send(24'h000150);
        chk(lane(3), 32'd0, "R10 lanes cleared");
        chk(lane(5), 32'h0000_0001, "R2 lane 5");

        finish_run();
    end

endmodule